// File: doc/BRIEF.md
# Event-Paced DAC Code Controller

This block is the digital front end of a digital-to-analog converter. Software reaches it over a small register bus. Writing the immediate-code register changes the converter code on the next clock edge. Writing the staged-code register parks a value in a one-entry holding slot. The value moves into the converter code only when a hardware trigger strobe arrives and triggering is enabled. Pacing conversions by hardware strobes in this way gives evenly spaced output samples, which suits waveform synthesis and audio playback.

The block tracks three conditions as sticky flags:
- the slot has just been drained;
- a trigger found the slot empty;
- a data-write synchronization has finished.

Each flag can be routed to a single interrupt line through a set/clear enable pair. When the slot drains, the block can also emit a one-cycle strobe, so that another agent can refill it. Every accepted data write starts a fixed busy window that models a synchronization stage, and data writes made during that window are dropped.

Top module: `dac_evt_ctrl`

## Requirements
- R1: After reset the converter code is 0, the slot is empty, the flag register (offset 5) reads 1 (bit0 drained set, bit1 starved and bit2 sync-done clear), enables read 0, busy (offset 6 bit0) is 0, and `irq` and `evt_out` are low.
- R2: A write to offset 0 while not busy sets `dac_code` and the offset 0 readback to the low 10 data bits after that clock edge.
- R3: A write to offset 1 while not busy fills the slot and leaves `dac_code` unchanged.
- R4: With trigger enabled (offset 2 bit0), a `evt_in` strobe with a full slot copies the slot into `dac_code`, empties the slot and sets flag bit0. With strobe output enabled (offset 2 bit1), `evt_out` is high for exactly the one cycle after that edge.
- R5: An enabled strobe with an empty slot sets flag bit1 and leaves `dac_code` unchanged.
- R6: With offset 2 bit0 clear, `evt_in` has no effect on the code, the slot or the flags.
- R7: An accepted data write makes busy read 1 for exactly 3 cycles, and flag bit2 is set on the edge where busy drops.
- R8: Writes to offsets 0 or 1 while busy is 1 are ignored.
- R9: Writing 1 to a bit of offset 5 clears that flag. A set event in the same cycle wins over the clear.
- R10: Writing 1s to offset 3 sets enable bits, and writing 1s to offset 4 clears them (both read back the enables). `irq` is the OR over the three flags ANDed with their enables.
- R11: With offset 2 bit1 clear, a drain produces no `evt_out` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| evt_in | input | 1 | Trigger strobe, one cycle per conversion |
| evt_out | output | 1 | One-cycle pulse when the slot drains |
| irq | output | 1 | Interrupt request |
| dac_code | output | 10 | Active converter code |

## Verification
The hardest case to reach is a flag being set and cleared in the same cycle. The bench gets there by holding a flag-clear write and an enabled trigger strobe on an empty slot in one cycle, then checking that the starved flag survives. Writes that land inside the busy window are provoked by issuing a second data write on the cycle right after the first. The bench then checks that neither the code nor the slot took the dropped value, using a later trigger to reveal the slot state.

// File: rtl/dac_evt_pkg.sv
// Package: register offsets and flag positions shared by the DAC controller.
// Assumes a 3-bit register offset and a 16-bit bus.
package dac_evt_pkg;
    localparam int ADDR_W  = 3;
    localparam int BUS_W   = 16;
    localparam int FLAG_N  = 3;

    localparam logic [ADDR_W-1:0] OFS_CODE  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAGE = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_EVCFG = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_FLAGS = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd6;

    // flag bit positions
    localparam int FL_DRAIN  = 0;
    localparam int FL_STARVE = 1;
    localparam int FL_SYNC   = 2;

    localparam logic [FLAG_N-1:0] FLAG_RST = 3'b001;
endpackage

// File: rtl/dac_sync_tracker.sv
// Module: models the data-write synchronization stage.
// An accepted write loads a down-counter. Busy is high while it is nonzero,
// and done pulses on the edge where it reaches zero.
// Assumes start is only asserted while busy is low.
module dac_sync_tracker #(
    parameter int SYNC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(SYNC_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on accepted write, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(SYNC_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1)) && !start;

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SYNC_CYC));
    a_r8_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r7_window_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/dac_code_path.sv
// Module: active converter code, one-entry staging slot and drain strobe.
// A direct write beats a slot transfer for the code. A staged write refills the
// slot after any same-cycle transfer, so the slot then stays full.
module dac_code_path #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_wr,
    input  logic              stage_wr,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              evt_in,
    input  logic              trig_en,
    input  logic              emit_en,
    output logic [DATA_W-1:0] code_q,
    output logic [DATA_W-1:0] stage_q,
    output logic              drain_set,
    output logic              starve_set,
    output logic              evt_out
);
    logic full_q;
    logic fire;

    assign fire       = evt_in && trig_en;
    assign drain_set  = fire && full_q && !stage_wr;
    assign starve_set = fire && !full_q;

    // Active code: direct write first, then transfer from the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (code_wr)
            code_q <= wr_val;
        else if (fire && full_q)
            code_q <= stage_q;
    end

    // Staging slot contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            full_q  <= 1'b0;
        end else if (stage_wr) begin
            stage_q <= wr_val;
            full_q  <= 1'b1;
        end else if (fire) begin
            full_q  <= 1'b0;
        end
    end

    // Registered one-cycle strobe on entry into the empty state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_out <= 1'b0;
        else
            evt_out <= drain_set && emit_en;
    end

    a_r5_starve_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !full_q && !code_wr) |=> $stable(code_q));
    a_r4_transfer_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && full_q && !code_wr) |=> (code_q == $past(stage_q)));
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |=> !evt_out);
    a_r11_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_en |=> !evt_out);
    a_r6_trig_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !code_wr && !stage_wr) |=> ($stable(code_q) && $stable(full_q)));
endmodule

// File: rtl/dac_irq_unit.sv
// Module: sticky flags with write-one-to-clear, set/clear enables and the irq line.
// A set in the same cycle as a clear wins.
module dac_irq_unit #(
    parameter int FLAG_N = 3,
    parameter logic [FLAG_N-1:0] FLAG_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic [FLAG_N-1:0] clr_vec,
    input  logic [FLAG_N-1:0] en_set,
    input  logic [FLAG_N-1:0] en_clr,
    output logic [FLAG_N-1:0] flags_q,
    output logic [FLAG_N-1:0] enab_q,
    output logic              irq
);
    // Per-flag update, generated for each source.
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= FLAG_RST[i];
            else if (set_vec[i])
                flags_q[i] <= 1'b1;
            else if (clr_vec[i])
                flags_q[i] <= 1'b0;
        end
    end

    // Enable mask: set register ORs in, clear register masks out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enab_q <= '0;
        else
            enab_q <= (enab_q | en_set) & ~en_clr;
    end

    assign irq = |(flags_q & enab_q);

    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_q == '0) |-> !irq);
endmodule

// File: rtl/dac_evt_ctrl.sv
// Module: top of the event-paced DAC code controller.
// Decodes the register bus, gates data writes by the sync busy window and
// wires the code path, sync tracker and interrupt unit together.
// Read data is combinational on bus_addr.
module dac_evt_ctrl
    import dac_evt_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SYNC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              evt_in,
    output logic              evt_out,
    output logic              irq,
    output logic [DATA_W-1:0] dac_code
);
    logic              busy, sync_done;
    logic              code_wr, stage_wr;
    logic [1:0]        evcfg_q;
    logic [DATA_W-1:0] stage_q;
    logic              drain_set, starve_set;
    logic [FLAG_N-1:0] set_vec, clr_vec, en_set, en_clr, flags_q, enab_q;

    assign code_wr  = bus_wen && (bus_addr == OFS_CODE)  && !busy;
    assign stage_wr = bus_wen && (bus_addr == OFS_STAGE) && !busy;

    // Event configuration: bit0 trigger enable, bit1 strobe output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evcfg_q <= '0;
        else if (bus_wen && bus_addr == OFS_EVCFG)
            evcfg_q <= bus_wdata[1:0];
    end

    dac_sync_tracker #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .start (code_wr || stage_wr),
        .busy  (busy),
        .done  (sync_done)
    );

    dac_code_path #(.DATA_W(DATA_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_wr    (code_wr),
        .stage_wr   (stage_wr),
        .wr_val     (bus_wdata[DATA_W-1:0]),
        .evt_in     (evt_in),
        .trig_en    (evcfg_q[0]),
        .emit_en    (evcfg_q[1]),
        .code_q     (dac_code),
        .stage_q    (stage_q),
        .drain_set  (drain_set),
        .starve_set (starve_set),
        .evt_out    (evt_out)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FL_DRAIN]  = drain_set;
        set_vec[FL_STARVE] = starve_set;
        set_vec[FL_SYNC]   = sync_done;
    end

    assign clr_vec = (bus_wen && bus_addr == OFS_FLAGS) ? bus_wdata[FLAG_N-1:0] : '0;
    assign en_set  = (bus_wen && bus_addr == OFS_ENSET) ? bus_wdata[FLAG_N-1:0] : '0;
    assign en_clr  = (bus_wen && bus_addr == OFS_ENCLR) ? bus_wdata[FLAG_N-1:0] : '0;

    dac_irq_unit #(.FLAG_N(FLAG_N), .FLAG_RST(FLAG_RST)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .flags_q (flags_q),
        .enab_q  (enab_q),
        .irq     (irq)
    );

    // Register readback multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CODE:  bus_rdata[DATA_W-1:0] = dac_code;
            OFS_STAGE: bus_rdata[DATA_W-1:0] = stage_q;
            OFS_EVCFG: bus_rdata[1:0]        = evcfg_q;
            OFS_ENSET,
            OFS_ENCLR: bus_rdata[FLAG_N-1:0] = enab_q;
            OFS_FLAGS: bus_rdata[FLAG_N-1:0] = flags_q;
            OFS_STAT:  bus_rdata[0]          = busy;
            default:   bus_rdata             = '0;
        endcase
    end

    a_r8_busy_drops_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_STAGE && busy) |=> $stable(stage_q));
    a_r8_busy_drops_code: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_CODE && busy && !evt_in) |=> $stable(dac_code));
endmodule

// File: tb/tb_dac_evt_ctrl.sv
module tb_dac_evt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        evt_in = 1'b0;
    logic        evt_out, irq;
    logic [9:0]  dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dac_evt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .evt_out(evt_out), .irq(irq), .dac_code(dac_code)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
    endtask

    task automatic idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); chk("R1 code", v, 0);
        chk("R1 dac_code", dac_code, 0);
        rd(3'd5, v); chk("R1 flags", v, 16'h1);
        rd(3'd3, v); chk("R1 enables", v, 0);
        rd(3'd6, v); chk("R1 busy", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 evt_out", evt_out, 0);
    endtask

    task automatic t_direct_and_busy();
        logic [15:0] v;
        wr(3'd0, 16'hF155);
        chk("R2 dac_code", dac_code, 10'h155);
        rd(3'd0, v); chk("R2 readback", v, 16'h155);
        rd(3'd6, v); chk("R7 busy c1", v, 1);
        @(negedge clk); rd(3'd6, v); chk("R7 busy c2", v, 1);
        rd(3'd5, v); chk("R7 sync not yet", v[2], 0);
        @(negedge clk); rd(3'd6, v); chk("R7 busy c3", v, 1);
        @(negedge clk); rd(3'd6, v); chk("R7 busy over", v, 0);
        rd(3'd5, v); chk("R7 sync flag", v[2], 1);
        wr(3'd5, 16'h7);
        rd(3'd5, v); chk("R9 w1c all", v, 0);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        wr(3'd0, 16'd5);
        wr(3'd0, 16'd9);
        chk("R8 code write dropped", dac_code, 10'd5);
        idle();
        wr(3'd2, 16'h1);
        wr(3'd0, 16'd7);
        wr(3'd1, 16'h22);
        idle();
        wr(3'd5, 16'h7);
        pulse();
        rd(3'd5, v); chk("R8 stage write dropped (starve)", v[1], 1);
        chk("R8 code kept", dac_code, 10'd7);
        wr(3'd5, 16'h7);
    endtask

    task automatic t_staged();
        logic [15:0] v;
        wr(3'd2, 16'h3);
        wr(3'd1, 16'h2AA);
        chk("R3 code unchanged", dac_code, 10'd7);
        idle();
        wr(3'd5, 16'h7);
        pulse();
        chk("R4 code loaded", dac_code, 10'h2AA);
        chk("R4 evt_out pulse", evt_out, 1);
        rd(3'd5, v); chk("R4 drain flag", v, 16'h1);
        @(negedge clk);
        chk("R4 evt_out one cycle", evt_out, 0);
        wr(3'd5, 16'h7);
        pulse();
        rd(3'd5, v); chk("R5 starve flag", v, 16'h2);
        chk("R5 code held", dac_code, 10'h2AA);
        chk("R5 no evt_out", evt_out, 0);
        wr(3'd5, 16'h7);
    endtask

    task automatic t_trig_off();
        logic [15:0] v;
        wr(3'd2, 16'h2);
        wr(3'd1, 16'h011);
        idle();
        wr(3'd5, 16'h7);
        pulse();
        chk("R6 code unchanged", dac_code, 10'h2AA);
        rd(3'd5, v); chk("R6 no flags", v, 0);
        wr(3'd2, 16'h1);
        pulse();
        chk("R6 slot kept", dac_code, 10'h011);
        chk("R11 no evt_out", evt_out, 0);
        rd(3'd5, v); chk("R11 drain flag", v, 16'h1);
        wr(3'd5, 16'h7);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(3'd3, 16'h2);
        rd(3'd4, v); chk("R10 enables", v, 16'h2);
        chk("R10 irq idle", irq, 0);
        pulse();
        chk("R10 irq on starve", irq, 1);
        // clear and starve in the same cycle: set wins
        @(negedge clk);
        evt_in = 1'b1; bus_wen = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h2;
        @(negedge clk);
        evt_in = 1'b0; bus_wen = 1'b0;
        rd(3'd5, v); chk("R9 set wins", v[1], 1);
        wr(3'd4, 16'h2);
        rd(3'd3, v); chk("R10 enable cleared", v, 0);
        chk("R10 irq masked", irq, 0);
        wr(3'd5, 16'h2);
        rd(3'd5, v); chk("R9 cleared", v[1], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_and_busy();
        t_busy_ignore();
        t_staged();
        t_trig_off();
        t_irq();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule